// File: doc/BRIEF.md
# Slot-Mapped Audio Serial Transmitter

This block drives the data pin of a multichannel audio serial port whose bit clock and frame sync come from elsewhere. It holds one sample word for each of eight channels and sends each sample, MSB first, in a 32-bit slot that is picked for that channel by configuration. A frame holds up to 64 slots. Any enabled channel may take any slot, and slots may be left empty. An empty slot is either released (output enable low) or driven low. Three framings are supported: TDM, where one frame sync edge starts a 64-slot frame; left-justified, where the two frame sync levels split the frame into a first half (slots 0 to 31) and a second half (slots 32 to 63); and I2S-style, which uses the same halves but starts the data one bit clock after each frame sync change.

The block runs on a fast system clock and oversamples the bit clock and frame sync. A launch edge of the conditioned bit clock is a system-clock cycle in which the conditioned bit clock changes to the level chosen by `launch_rise`. All output changes follow launch edges. Frame sync is looked at only on launch edges. The sequencer has three states. `ST_IDLE` holds the output released after reset. `ST_GAP` is the one-bit delay of I2S mode. `ST_SHIFT` walks a bit position counter. The transitions are these: IDLE to SHIFT on a frame start in TDM or left-justified mode. IDLE to GAP on a frame start in I2S mode. SHIFT to SHIFT, restarting at position 0, on a frame start in TDM or left-justified mode. SHIFT to GAP on any frame sync change in I2S mode. GAP to SHIFT on the next launch edge. A launch edge in SHIFT with no frame sync event moves the counter on by one, and the counter stops one past the last bit of slot 63.

Top module: `slot_audio_tx`

## Requirements
- R1: After reset, and until the first frame start, `sd_oe` and `sd_o` are both 0, whatever the fill setting.
- R2: A frame start is a launch edge at which the conditioned frame sync (`fsync ^ fs_inv`) is 1 and was 0 at the previous launch edge. In TDM (`fmt` 2'b00, or 2'b11, which acts the same), bit position 0 is sent on that edge. Each later launch edge sends the next position. Position p belongs to slot p/32 and carries sample bit 31 - (p mod 32).
- R3: In left-justified mode (`fmt` 2'b10), a launch edge at which the conditioned frame sync falls from 1 to 0 sends position 1024, which is the MSB of slot 32. The frame start sends position 0.
- R4: In I2S mode (`fmt` 2'b01), the launch edge at which the conditioned frame sync changes sends the position that follows the last one sent. If the block has come straight from reset, that edge is an empty slot instead. The next launch edge sends position 0 after a rise and position 1024 after a fall.
- R5: Channel c (bits [32c+31:32c] of `samples`) is sent in the slot given by `ch_slot[6c+5:6c]` when `ch_en[c]` is 1. Slots need not be consecutive or in channel order, and all channels may share one half.
- R6: A channel whose `ch_en` bit is 0 never drives any slot, even if its slot number matches.
- R7: During a slot that no enabled channel claims, and at positions past slot 63, `sd_oe` equals `fill_low` and `sd_o` is 0. `sd_o` is 0 whenever `sd_oe` is 0.
- R8: If several enabled channels share a slot, the lowest-numbered channel is sent.
- R9: All samples are captured on the launch edge that sends position 0. Changes to `samples` after that edge do not appear in that frame.
- R10: The conditioned bit clock is `bclk ^ bclk_inv`. Launch edges are its rising edges when `launch_rise` is 1 and its falling edges when it is 0. Between launch edges, with the configuration held, `sd_o` and `sd_oe` do not change.
- R11: Setting `fs_inv` inverts the frame sync level, so framing follows the conditioned level in every format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Bit clock from the bus |
| fsync | input | 1 | Frame sync from the bus |
| fmt | input | 2 | 00/11 TDM, 01 I2S-style, 10 left-justified |
| bclk_inv | input | 1 | Inverts the bit clock |
| fs_inv | input | 1 | Inverts the frame sync |
| launch_rise | input | 1 | 1: launch on rising conditioned bit clock, 0: on falling |
| fill_low | input | 1 | 1: drive empty slots low, 0: release them |
| ch_en | input | 8 | Per-channel enable |
| ch_slot | input | 48 | Six-bit slot number per channel |
| samples | input | 256 | 32-bit sample word per channel |
| sd_o | output | 1 | Serial data |
| sd_oe | output | 1 | Output enable for the data pad |

## Verification
The bench goes after empty slots between claimed ones. A design that packed the used slots together would send the third channel one slot early, and a design that ignored `fill_low` would show the wrong enable in the gap. It checks the I2S phase boundary with halves exactly four slots long. Here the last bit of a half lands on the frame sync change, so an off-by-one in the gap handling shows up as a wrong LSB, or as a first bit that leaks out after reset. It places two enabled channels and one disabled channel on the same slot, which exposes a reversed priority and a disabled channel that still drives. It also rewrites every sample just after position 0, which catches a holding register that loads late or tracks its input.

// File: rtl/astx_pkg.sv
package astx_pkg;

    typedef enum logic [1:0] {
        FMT_TDM  = 2'b00,
        FMT_I2S  = 2'b01,
        FMT_LJ   = 2'b10,
        FMT_TDM2 = 2'b11
    } frame_fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_GAP   = 2'b01,
        ST_SHIFT = 2'b10
    } tx_state_e;

endpackage

// File: rtl/astx_edge.sv
module astx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    input  logic bclk_inv,
    input  logic fs_inv,
    input  logic launch_rise,
    output logic launch,
    output logic fs_rise,
    output logic fs_fall
);
    logic b_eff;
    logic b_q;
    logic f_eff;
    logic f_q;

    assign b_eff   = bclk ^ bclk_inv;
    assign f_eff   = fsync ^ fs_inv;
    assign launch  = (b_eff != b_q) && (b_eff == launch_rise);
    assign fs_rise = launch && f_eff && !f_q;
    assign fs_fall = launch && !f_eff && f_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= 1'b0;
            f_q <= 1'b0;
        end else begin
            b_q <= b_eff;
            if (launch) begin
                f_q <= f_eff;
            end
        end
    end
endmodule

// File: rtl/astx_slot_lookup.sv
module astx_slot_lookup #(
    parameter int NCH        = 8,
    parameter int SAMPLE_W   = 32,
    parameter int SLOT_IDX_W = 6,
    parameter int BIT_IDX_W  = 5
) (
    input  logic                      pos_valid,
    input  logic [SLOT_IDX_W-1:0]     slot_idx,
    input  logic [BIT_IDX_W-1:0]      bit_idx,
    input  logic [NCH-1:0]            ch_en,
    input  logic [NCH*SLOT_IDX_W-1:0] ch_slot,
    input  logic [NCH*SAMPLE_W-1:0]   hold,
    output logic                      hit,
    output logic                      bit_val
);
    logic [NCH-1:0]      match;
    logic [SAMPLE_W-1:0] word;

    for (genvar g = 0; g < NCH; g++) begin : g_match
        assign match[g] = pos_valid && ch_en[g]
                          && (ch_slot[g*SLOT_IDX_W +: SLOT_IDX_W] == slot_idx);
    end

    // Scan from the top so the lowest matching channel is the last one written.
    always_comb begin
        hit  = 1'b0;
        word = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit  = 1'b1;
                word = hold[i*SAMPLE_W +: SAMPLE_W];
            end
        end
        bit_val = hit && word[BIT_IDX_W'(SAMPLE_W - 1) - bit_idx];
    end
endmodule

// File: rtl/slot_audio_tx.sv
module slot_audio_tx
    import astx_pkg::*;
#(
    parameter int NCH        = 8,
    parameter int SAMPLE_W   = 32,
    parameter int NSLOT      = 64,
    localparam int SLOT_IDX_W = $clog2(NSLOT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bclk,
    input  logic                      fsync,
    input  logic [1:0]                fmt,
    input  logic                      bclk_inv,
    input  logic                      fs_inv,
    input  logic                      launch_rise,
    input  logic                      fill_low,
    input  logic [NCH-1:0]            ch_en,
    input  logic [NCH*SLOT_IDX_W-1:0] ch_slot,
    input  logic [NCH*SAMPLE_W-1:0]   samples,
    output logic                      sd_o,
    output logic                      sd_oe
);
    localparam int BIT_IDX_W = $clog2(SAMPLE_W);
    localparam int TOTAL     = NSLOT * SAMPLE_W;
    localparam int POS_W     = $clog2(TOTAL) + 1;
    localparam int HALF      = TOTAL / 2;

    tx_state_e               state, state_nx;
    logic [POS_W-1:0]        cnt, cnt_nx, cnt_inc;
    logic [POS_W-1:0]        base, base_nx;
    logic                    spill, spill_nx;
    logic                    capture;
    logic [NCH*SAMPLE_W-1:0] hold;

    logic launch, fs_rise, fs_fall;
    logic is_i2s, is_lj;
    logic pos_ok, hit, bit_val;

    astx_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk       (bclk),
        .fsync      (fsync),
        .bclk_inv   (bclk_inv),
        .fs_inv     (fs_inv),
        .launch_rise(launch_rise),
        .launch     (launch),
        .fs_rise    (fs_rise),
        .fs_fall    (fs_fall)
    );

    assign is_i2s  = (fmt == FMT_I2S);
    assign is_lj   = (fmt == FMT_LJ);
    assign cnt_inc = (cnt == POS_W'(TOTAL)) ? cnt : cnt + POS_W'(1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            base  <= '0;
            spill <= 1'b0;
            hold  <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            base  <= base_nx;
            spill <= spill_nx;
            if (capture) begin
                hold <= samples;
            end
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        base_nx  = base;
        spill_nx = spill;
        capture  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (fs_rise) begin
                    if (is_i2s) begin
                        state_nx = ST_GAP;
                        base_nx  = '0;
                        spill_nx = 1'b0;
                    end else begin
                        state_nx = ST_SHIFT;
                        cnt_nx   = '0;
                        capture  = 1'b1;
                    end
                end
            end
            ST_SHIFT: begin
                if (fs_rise) begin
                    if (is_i2s) begin
                        state_nx = ST_GAP;
                        cnt_nx   = cnt_inc;
                        base_nx  = '0;
                        spill_nx = 1'b1;
                    end else begin
                        cnt_nx  = '0;
                        capture = 1'b1;
                    end
                end else if (fs_fall && is_i2s) begin
                    state_nx = ST_GAP;
                    cnt_nx   = cnt_inc;
                    base_nx  = POS_W'(HALF);
                    spill_nx = 1'b1;
                end else if (fs_fall && is_lj) begin
                    cnt_nx = POS_W'(HALF);
                end else if (launch) begin
                    cnt_nx = cnt_inc;
                end
            end
            ST_GAP: begin
                if (launch) begin
                    state_nx = ST_SHIFT;
                    cnt_nx   = base;
                    capture  = (base == '0);
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    astx_slot_lookup #(
        .NCH       (NCH),
        .SAMPLE_W  (SAMPLE_W),
        .SLOT_IDX_W(SLOT_IDX_W),
        .BIT_IDX_W (BIT_IDX_W)
    ) u_lookup (
        .pos_valid(pos_ok),
        .slot_idx (cnt[POS_W-2:BIT_IDX_W]),
        .bit_idx  (cnt[BIT_IDX_W-1:0]),
        .ch_en    (ch_en),
        .ch_slot  (ch_slot),
        .hold     (hold),
        .hit      (hit),
        .bit_val  (bit_val)
    );

    // Outputs
    always_comb begin
        pos_ok = ((state == ST_SHIFT) || ((state == ST_GAP) && spill))
                 && (cnt < POS_W'(TOTAL));
        if (state == ST_IDLE) begin
            sd_oe = 1'b0;
            sd_o  = 1'b0;
        end else begin
            sd_oe = hit || fill_low;
            sd_o  = bit_val;
        end
    end
endmodule

// File: rtl/astx_chk.sv
module astx_chk #(
    parameter int NCH        = 8,
    parameter int SLOT_IDX_W = 6
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bclk,
    input logic                      fsync,
    input logic                      bclk_inv,
    input logic                      fs_inv,
    input logic                      launch_rise,
    input logic                      fill_low,
    input logic [NCH-1:0]            ch_en,
    input logic [NCH*SLOT_IDX_W-1:0] ch_slot,
    input logic                      sd_o,
    input logic                      sd_oe
);
    logic b_now, f_now, launch_c;
    logic b_q, f_q, seen, launch_q, fill_q;
    logic [NCH-1:0]            en_q;
    logic [NCH*SLOT_IDX_W-1:0] slot_q;

    assign b_now    = bclk ^ bclk_inv;
    assign f_now    = fsync ^ fs_inv;
    assign launch_c = (b_now != b_q) && (b_now == launch_rise);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q      <= 1'b0;
            f_q      <= 1'b0;
            seen     <= 1'b0;
            launch_q <= 1'b0;
            fill_q   <= 1'b0;
            en_q     <= '0;
            slot_q   <= '0;
        end else begin
            b_q      <= b_now;
            launch_q <= launch_c;
            fill_q   <= fill_low;
            en_q     <= ch_en;
            slot_q   <= ch_slot;
            if (launch_c) begin
                f_q <= f_now;
                if (f_now && !f_q) begin
                    seen <= 1'b1;
                end
            end
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> !sd_oe);

    // R6
    none_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en == '0) |-> !sd_o);

    // R7
    fill_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && fill_low) |-> sd_oe);

    // R7
    released_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_oe |-> !sd_o);

    // R10
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!launch_q && (ch_en == en_q) && (ch_slot == slot_q) && (fill_low == fill_q))
        |-> $stable({sd_o, sd_oe}));
endmodule

bind slot_audio_tx astx_chk #(
    .NCH       (NCH),
    .SLOT_IDX_W(SLOT_IDX_W)
) u_astx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk       (bclk),
    .fsync      (fsync),
    .bclk_inv   (bclk_inv),
    .fs_inv     (fs_inv),
    .launch_rise(launch_rise),
    .fill_low   (fill_low),
    .ch_en      (ch_en),
    .ch_slot    (ch_slot),
    .sd_o       (sd_o),
    .sd_oe      (sd_oe)
);

// File: tb/tb_slot_audio_tx.sv
module tb_slot_audio_tx;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bclk = 1'b0;
    logic         fsync = 1'b0;
    logic [1:0]   fmt = 2'b00;
    logic         bclk_inv = 1'b0;
    logic         fs_inv = 1'b0;
    logic         launch_rise = 1'b1;
    logic         fill_low = 1'b0;
    logic [7:0]   ch_en = '0;
    logic [47:0]  ch_slot = '0;
    logic [255:0] samples = '0;
    logic         sd_o;
    logic         sd_oe;

    logic [255:0] exp_hold = '0;
    logic [1:0]   last_exp = 2'b00;
    int           n_chk = 0;
    int           n_fail = 0;

    always #5 clk = ~clk;

    slot_audio_tx dut (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .fmt(fmt),
        .bclk_inv(bclk_inv), .fs_inv(fs_inv), .launch_rise(launch_rise),
        .fill_low(fill_low), .ch_en(ch_en), .ch_slot(ch_slot),
        .samples(samples), .sd_o(sd_o), .sd_oe(sd_oe)
    );

    task automatic check(string tag, logic [1:0] got, logic [1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: oe/data got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_out(bit valid, int pos);
        if (!valid || pos >= 2048) return {fill_low, 1'b0};
        for (int c = 0; c < 8; c++) begin
            if (ch_en[c] && (int'(ch_slot[c*6 +: 6]) == pos / 32))
                return {1'b1, exp_hold[c*32 + 31 - (pos % 32)]};
        end
        return {fill_low, 1'b0};
    endfunction

    task automatic new_samples();
        for (int c = 0; c < 8; c++) samples[c*32 +: 32] = $urandom;
    endtask

    task automatic set_slot(int c, int s);
        ch_slot[c*6 +: 6] = 6'(s);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bclk  = (~launch_rise) ^ bclk_inv;
        fsync = fs_inv;
        repeat (3) @(negedge clk);
        rst_n    = 1'b1;
        last_exp = 2'b00;
        @(negedge clk);
    endtask

    // One bit clock period: non-launch half, then launch edge; returns at the sample point.
    task automatic do_launch(logic fs);
        @(negedge clk);
        bclk  = (~launch_rise) ^ bclk_inv;
        fsync = fs ^ fs_inv;
        @(negedge clk);
        check("R10 output held between launch edges", {sd_oe, sd_o}, last_exp);
        bclk = launch_rise ^ bclk_inv;
        @(negedge clk);
    endtask

    task automatic run(int len, int nfr, string tag);
        bit tdm = (fmt == 2'b00) || (fmt == 2'b11);
        bit i2s = (fmt == 2'b01);
        int total = tdm ? len : 2 * len;
        bit first = 1'b1;
        for (int f = 0; f < nfr; f++) begin
            for (int k = 0; k < total; k++) begin
                logic fs;
                bit valid = 1'b1;
                bit cap = 1'b0;
                int pos;
                logic [1:0] e;
                if (tdm) begin
                    fs = (k == 0); pos = k; cap = (k == 0);
                end else if (!i2s) begin
                    fs = (k < len);
                    pos = (k < len) ? k : 1024 + k - len;
                    cap = (k == 0);
                end else begin
                    fs = (k < len);
                    if (k == 0) begin valid = !first; pos = 1024 + len - 1; end
                    else if (k < len) begin pos = k - 1; cap = (k == 1); end
                    else if (k == len) pos = len - 1;
                    else pos = 1024 + k - len - 1;
                end
                if (cap) exp_hold = samples;
                do_launch(fs);
                e = exp_out(valid, pos);
                check(tag, {sd_oe, sd_o}, e);
                last_exp = e;
                if (cap) new_samples();   // R9: rewrite right after capture
            end
            first = 1'b0;
        end
    endtask

    task automatic cfg(int f, bit binv, bit finv, bit lr, bit fill);
        fmt = 2'(f); bclk_inv = binv; fs_inv = finv; launch_rise = lr; fill_low = fill;
    endtask

    initial begin
        #1_500_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung, got running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd7301));
        new_samples();

        // R1: released after reset until a frame start, even with fill set
        cfg(0, 0, 0, 1, 1);
        ch_en = 8'hFF; ch_slot = '0;
        do_reset();
        for (int i = 0; i < 4; i++) begin
            do_launch(1'b0);
            check("R1 quiet before first frame start", {sd_oe, sd_o}, 2'b00);
        end

        // R5 R6 R7: gap at slot 1 (disabled ch1 also names slot 1), released
        cfg(0, 0, 0, 1, 0);
        ch_en = 8'b0000_0101;
        ch_slot = '0; set_slot(0, 0); set_slot(1, 1); set_slot(2, 2); set_slot(3, 3);
        do_reset();
        run(128, 2, "R5 R6 R7 R9 sparse slots, empty released");
        cfg(0, 0, 0, 1, 1);
        do_reset();
        run(128, 2, "R7 sparse slots, empty driven low");

        // R8: duplicate slot, lower channel wins; disabled ch1 on same slot
        cfg(0, 0, 0, 1, 0);
        ch_en = 8'b0100_1000;
        set_slot(3, 1); set_slot(6, 1); set_slot(1, 1);
        do_reset();
        run(128, 2, "R8 R6 shared slot priority");

        // R3: left-justified with both halves used
        cfg(2, 0, 0, 1, 1);
        ch_en = 8'b1001_0011;
        set_slot(0, 33); set_slot(1, 0); set_slot(4, 3); set_slot(7, 32);
        do_reset();
        run(128, 2, "R3 left-justified halves");

        // R4: I2S, all channels in the first half, half exactly four slots
        cfg(1, 0, 0, 1, 0);
        ch_en = 8'b0000_1111;
        set_slot(0, 0); set_slot(1, 1); set_slot(2, 2); set_slot(3, 3);
        do_reset();
        run(128, 3, "R4 R5 I2S all in first half");

        // R4: I2S with second-half slots and a longer half
        cfg(1, 0, 0, 1, 1);
        ch_en = 8'b1110_0001;
        set_slot(0, 35); set_slot(5, 0); set_slot(6, 32); set_slot(7, 4);
        do_reset();
        run(160, 2, "R4 I2S second half");

        // R10 R11: inverted clocks and falling launch edge
        cfg(0, 1, 1, 0, 0);
        ch_en = 8'b0011_0000;
        set_slot(4, 1); set_slot(5, 3);
        do_reset();
        run(128, 2, "R10 R11 TDM inverted polarities");
        cfg(2, 0, 1, 0, 1);
        ch_en = 8'b0000_0110;
        set_slot(1, 34); set_slot(2, 2);
        do_reset();
        run(128, 2, "R11 R10 left-justified inverted frame sync");

        // R2: format code 11 acts as TDM; full 64-slot frame reaching slot 63
        cfg(3, 0, 0, 1, 0);
        ch_en = 8'b1000_0001;
        set_slot(0, 62); set_slot(7, 63);
        do_reset();
        run(2048, 2, "R2 TDM alias, full frame with slot 63");

        // Random mix
        for (int it = 0; it < 8; it++) begin
            int f = $urandom_range(0, 3);
            int len = (f == 0 || f == 3) ? 32 * $urandom_range(4, 8) : 32 * $urandom_range(4, 5);
            cfg(f, $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                $urandom_range(0, 1));
            ch_en = 8'($urandom);
            for (int c = 0; c < 8; c++) begin
                if (f == 0 || f == 3) set_slot(c, $urandom_range(0, len / 32 - 1));
                else set_slot(c, $urandom_range(0, 1) * 32 + $urandom_range(0, 3));
            end
            do_reset();
            run(len, 2, "R5 R8 R9 R2 random configuration");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule